// File: doc/BRIEF.md
# Beat Frequency Detector Counter

This block turns two free-running oscillators of nearly equal frequency into raw count values for a random number source. Oscillator B clocks the whole block. Oscillator A enters as a data input and is sampled on every B edge. Because the two frequencies are close, the sampled level changes slowly and forms a beat signal. The length of each beat period, measured in B cycles, carries jitter from both oscillators. The closer the two frequencies are, the larger the count.

A voting window over the most recent samples of A smooths the beat signal, so that a short bubble near a transition does not split one beat period into two. A counter runs between consecutive rising edges of the filtered beat. At each rising edge the counter value is reported with a one-cycle strobe, and the counter starts again from zero.

An enable input starts and stops measurement. While it is low, the sampling and counting registers stay still, which saves switching power. After each enable, the first beat edge only arms the counter, because the time before it does not cover a whole beat period. Downstream logic selects low-order bits from the reported counts.

Top module: `beatcnt_top`

## Requirements
- R1: While reset is asserted and after it is released, `count_o`, `count_valid_o` and `overflow_o` are all zero until the first report.
- R2: In steady state, each report on `count_o` equals the number of `clk_b` cycles between two consecutive rising edges of the beat signal on `osc_a`, for asymmetric and very short beat periods alike.
- R3: The count is 12 bits wide (CNT_W) and saturates instead of wrapping. A beat period of 4096 cycles or more reports 4095 with `overflow_o` = 1. A period of 4095 or less reports its exact length with `overflow_o` = 0.
- R4: A majority vote over the last five samples (VOTE_N) filters the beat signal. A single-cycle opposite sample inside a high or low phase of `osc_a` creates no extra edge, and the reported count stays equal to the true period.
- R5: `count_valid_o` is high for exactly one cycle per report. `count_o` and `overflow_o` change only in a cycle where `count_valid_o` is high, and they hold their value between reports.
- R6: After `enable` rises, the first beat rising edge produces no report. The first report after enabling is one full beat period.
- R7: While `enable` is low, no report is produced, the running counter does not advance, and `count_o` keeps its last value.
- R8: The counter restarts after every report, so successive reports of a steady beat do not accumulate: each one equals the period again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_b | input | 1 | Oscillator B, clock of the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_a | input | 1 | Oscillator A level, sampled on each `clk_b` edge |
| enable | input | 1 | Measurement request; counting runs only while high |
| count_o | output | CNT_W | Length of the last beat period in `clk_b` cycles |
| count_valid_o | output | 1 | One-cycle strobe marking a new `count_o` |
| overflow_o | output | 1 | High when the reported period exceeded the counter range |

## Verification
The assertions check on every cycle that the report strobe lasts a single cycle, that the reported value and flag hold between strobes, that a flagged report carries the saturated value, and that a low enable freezes the running counter and suppresses reports. Only the bench scenarios can show that the reported values are the correct periods. They drive `osc_a` with beat waves of known length, which covers short, asymmetric and near-range periods, the saturation boundary at 4095 and 4096, glitched phases, the discarded first period after enabling, and the restart after a pause.

// File: rtl/beatcnt_pkg.sv
package beatcnt_pkg;

    // Measurement control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // enable low, registers frozen
        ST_ARM  = 2'd1,  // waiting for the first aligned beat edge
        ST_RUN  = 2'd2   // counting whole beat periods
    } ctrl_state_e;

endpackage

// File: rtl/beatcnt_vote.sv
// Samples oscillator A on each B edge, keeps a short history of samples and
// derives a filtered beat level by majority vote; flags its rising edge.
module beatcnt_vote #(
    parameter int VOTE_N = 5
) (
    input  logic clk_b,
    input  logic rst_n,
    input  logic en,
    input  logic osc_a,
    output logic rise_o
);
    localparam int OW = $clog2(VOTE_N + 1);
    localparam int TH = VOTE_N / 2 + 1;

    typedef struct packed {
        logic              samp;
        logic [VOTE_N-1:0] hist;
        logic              filt;
    } vote_s;

    vote_s s_d, s_q;
    logic [OW-1:0] ones;
    logic          maj;

    always_comb begin
        ones = '0;
        for (int i = 0; i < VOTE_N; i++) begin
            ones = ones + OW'(s_q.hist[i]);
        end
        maj = (ones >= OW'(TH));

        s_d = s_q;
        if (en) begin
            s_d.samp = osc_a;
            s_d.hist = {s_q.hist[VOTE_N-2:0], s_q.samp};
            s_d.filt = maj;
        end else begin
            s_d = '0;
        end
        rise_o = en & maj & ~s_q.filt;
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/beatcnt_ctrl.sv
// Start/end control: arms on enable, discards the first partial period,
// then requests a report and a counter restart on every filtered beat edge.
module beatcnt_ctrl
    import beatcnt_pkg::*;
(
    input  logic clk_b,
    input  logic rst_n,
    input  logic en,
    input  logic rise,
    output logic clr_o,
    output logic inc_o,
    output logic latch_o
);
    typedef struct packed {
        ctrl_state_e st;
    } ctrl_s;

    ctrl_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        clr_o   = 1'b0;
        inc_o   = 1'b0;
        latch_o = 1'b0;
        if (!en) begin
            s_d.st = ST_IDLE;
        end else begin
            unique case (s_q.st)
                ST_IDLE: s_d.st = ST_ARM;
                ST_ARM: begin
                    if (rise) begin
                        s_d.st = ST_RUN;
                        clr_o  = 1'b1;
                    end
                end
                ST_RUN: begin
                    inc_o = 1'b1;
                    if (rise) begin
                        latch_o = 1'b1;
                        clr_o   = 1'b1;
                    end
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/beatcnt_counter.sv
// Saturating period counter with output latch and report strobe.
module beatcnt_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             latch,
    output logic [CNT_W-1:0] run_cnt_o,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] out;
        logic             vld;
        logic             ovf;
    } cnt_s;

    cnt_s s_d, s_q;
    logic at_max;

    always_comb begin
        at_max = (s_q.cnt == CNT_MAX);
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (latch) begin
            // the current cycle closes the period, so it is counted here
            s_d.out = at_max ? CNT_MAX : s_q.cnt + 1'b1;
            s_d.ovf = at_max;
            s_d.vld = 1'b1;
        end
        if (clr) begin
            s_d.cnt = '0;
        end else if (inc && !at_max) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_cnt_o = s_q.cnt;
    assign count_o   = s_q.out;
    assign valid_o   = s_q.vld;
    assign ovf_o     = s_q.ovf;

endmodule

// File: rtl/beatcnt_top.sv
module beatcnt_top #(
    parameter int CNT_W  = 12,
    parameter int VOTE_N = 5
) (
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             osc_a,
    input  logic             enable,
    output logic [CNT_W-1:0] count_o,
    output logic             count_valid_o,
    output logic             overflow_o
);
    logic             rise;
    logic             clr;
    logic             inc;
    logic             latch;
    logic [CNT_W-1:0] run_cnt;

    beatcnt_vote #(.VOTE_N(VOTE_N)) u_vote (
        .clk_b  (clk_b),
        .rst_n  (rst_n),
        .en     (enable),
        .osc_a  (osc_a),
        .rise_o (rise)
    );

    beatcnt_ctrl u_ctrl (
        .clk_b   (clk_b),
        .rst_n   (rst_n),
        .en      (enable),
        .rise    (rise),
        .clr_o   (clr),
        .inc_o   (inc),
        .latch_o (latch)
    );

    beatcnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_b     (clk_b),
        .rst_n     (rst_n),
        .clr       (clr),
        .inc       (inc),
        .latch     (latch),
        .run_cnt_o (run_cnt),
        .count_o   (count_o),
        .valid_o   (count_valid_o),
        .ovf_o     (overflow_o)
    );

endmodule

// File: rtl/beatcnt_checker.sv
module beatcnt_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk_b,
    input logic             rst_n,
    input logic             enable,
    input logic [CNT_W-1:0] count_o,
    input logic             count_valid_o,
    input logic             overflow_o,
    input logic [CNT_W-1:0] run_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_valid_pulse_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
        count_valid_o |=> !count_valid_o);

    p_hold_between_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
        !count_valid_o |-> ($stable(count_o) && $stable(overflow_o)));

    p_ovf_saturated_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
        (count_valid_o && overflow_o) |-> (count_o == CNT_MAX));

    p_count_nonzero_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
        count_valid_o |-> (count_o != '0));

    p_idle_quiet_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        !enable |=> !count_valid_o);

    p_idle_frozen_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        !enable |=> $stable(run_cnt));

endmodule

bind beatcnt_top beatcnt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_b         (clk_b),
    .rst_n         (rst_n),
    .enable        (enable),
    .count_o       (count_o),
    .count_valid_o (count_valid_o),
    .overflow_o    (overflow_o),
    .run_cnt       (run_cnt)
);

// File: tb/tb_beatcnt_top.sv
`timescale 1ns/1ps
module tb_beatcnt_top;
    localparam int CNT_W = 12;
    localparam int NV    = 6;
    // stimulus: low phase, high phase; expected: count, overflow
    localparam int LO  [NV] = '{10, 5, 100, 3, 2000, 2048};
    localparam int HI  [NV] = '{10, 7,  50, 3, 2095, 2048};
    localparam int EXPC[NV] = '{20, 12, 150, 6, 4095, 4095};
    localparam int EXPO[NV] = '{0,  0,   0, 0,    0,    1};

    logic             clk_b = 1'b0;
    logic             rst_n = 1'b0;
    logic             osc_a = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             count_valid_o;
    logic             overflow_o;

    int  errors = 0;
    int  checks = 0;
    int  lo_len = 10;
    int  hi_len = 10;
    bit  gen_on = 1'b0;
    bit  glitch = 1'b0;
    bit  found;
    int  waited;

    beatcnt_top #(.CNT_W(CNT_W), .VOTE_N(5)) dut (
        .clk_b         (clk_b),
        .rst_n         (rst_n),
        .osc_a         (osc_a),
        .enable        (enable),
        .count_o       (count_o),
        .count_valid_o (count_valid_o),
        .overflow_o    (overflow_o)
    );

    always #10 clk_b = ~clk_b;  // 50 MHz

    // beat wave generator on osc_a, driven at falling edges
    always begin
        if (gen_on) begin
            for (int i = 0; i < lo_len && gen_on; i++) begin
                osc_a = glitch && (i == lo_len / 2);
                @(negedge clk_b);
            end
            for (int i = 0; i < hi_len && gen_on; i++) begin
                osc_a = !(glitch && (i == hi_len / 2));
                @(negedge clk_b);
            end
        end else begin
            osc_a = 1'b0;
            @(negedge clk_b);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(input int limit);
        found  = 1'b0;
        waited = 0;
        while (!found && waited < limit) begin
            @(negedge clk_b);
            waited++;
            if (count_valid_o) found = 1'b1;
        end
    endtask

    task automatic start_run(input int lo, input int hi, input bit gl);
        enable = 1'b0;
        gen_on = 1'b0;
        repeat (10) @(negedge clk_b);
        lo_len = lo;
        hi_len = hi;
        glitch = gl;
        gen_on = 1'b1;
        enable = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk_b);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int last;
        repeat (5) @(negedge clk_b);
        chk("R1 count in reset", int'(count_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_b);
        chk("R1 count after reset", int'(count_o), 0);
        chk("R1 valid after reset", int'(count_valid_o), 0);
        chk("R1 overflow after reset", int'(overflow_o), 0);

        // table walk: R2 periods, R3 saturation boundary, R6 first report, R8 restart
        for (int v = 0; v < NV; v++) begin
            start_run(LO[v], HI[v], 1'b0);
            wait_valid(3 * (LO[v] + HI[v]) + 100);
            chk("R6 first report present", int'(found), 1);
            chk("R6 R2 first count is full period", int'(count_o), EXPC[v]);
            chk("R3 first overflow flag", int'(overflow_o), EXPO[v]);
            @(negedge clk_b);
            chk("R5 strobe one cycle", int'(count_valid_o), 0);
            wait_valid(2 * (LO[v] + HI[v]) + 100);
            chk("R8 second report present", int'(found), 1);
            chk("R8 R2 second count", int'(count_o), EXPC[v]);
            chk("R3 second overflow flag", int'(overflow_o), EXPO[v]);
        end

        // R4: single-cycle bubbles inside both phases
        start_run(20, 20, 1'b1);
        wait_valid(300);
        chk("R4 glitched first count", int'(count_o), 40);
        wait_valid(200);
        chk("R4 glitched second count", int'(count_o), 40);
        wait_valid(200);
        chk("R4 glitched third count", int'(count_o), 40);

        // R7: disable while the beat keeps running; R5 hold
        glitch = 1'b0;
        start_run(15, 15, 1'b0);
        wait_valid(300);
        chk("R2 count before pause", int'(count_o), 30);
        last = int'(count_o);
        @(negedge clk_b);
        enable = 1'b0;
        begin
            int seen = 0;
            int moved = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk_b);
                if (count_valid_o) seen++;
                if (int'(count_o) != last) moved++;
            end
            chk("R7 no report while disabled", seen, 0);
            chk("R7 R5 count held while disabled", moved, 0);
        end
        // re-enable mid-wave: first report is again a full period (R6)
        enable = 1'b1;
        wait_valid(300);
        chk("R6 full period after re-enable", int'(count_o), 30);
        chk("R3 no overflow after re-enable", int'(overflow_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule